// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Register Block

This block sits beside a cartridge's ROMs and turns a CPU's byte writes into bank selections. A small sparse set of write addresses drives three kinds of state. Four selectors choose which 8 KB program-ROM bank each quarter of the upper 32 KB CPU window shows. Eight selectors choose which 1 KB pattern-ROM bank each 1 KB slice of the low 8 KB video window shows. A two-bit code tells the video side how to mirror its nametables.

Address translation is purely combinational. The CPU address becomes a program-ROM address, and the video address becomes a pattern-ROM address. Each comes with a hit flag that says whether the input falls inside the translated window. The write port is a plain strobe with no ready signal. Every write is taken on the clock edge where the strobe is high, so the port has no back-pressure, and a write the map does not decode has no effect. The result of a write shows on the translated outputs from the cycle after that edge.

The number of 8 KB program banks is a parameter. The reset map places the first two banks at the bottom of the window and the last two banks at the top.

Top module: `cart_bank_regs`

## Requirements
- R1: After reset, the four program selectors, which serve CPU windows 0x8000, 0xA000, 0xC000 and 0xE000, hold banks 0, 1, N-2 and N-1, where N is the parameter PRG_BANKS.
- R2: After reset, 1 KB pattern selector k holds bank k for k from 0 to 7.
- R3: The mirroring output `mirror_mode` encodes 0 as vertical, 1 as horizontal, 2 as single-screen low and 3 as single-screen high. Reset selects 0.
- R4: A write to 0x42FE sets `mirror_mode` to 3 when data bit 4 is 1 and to 2 when data bit 4 is 0.
- R5: A write to 0x42FF sets `mirror_mode` to 1 when data bit 4 is 1 and to 0 when data bit 4 is 0.
- R6: A write to address 0x4504+j, for j from 0 to 3, loads program selector j with the whole data byte.
- R7: A write to address 0x4510+k, for k from 0 to 7, loads pattern selector k with the whole data byte.
- R8: `prg_addr` equals {selector[cpu_addr[14:13]], cpu_addr[12:0]}, and `prg_hit` equals cpu_addr[15].
- R9: `chr_addr` equals {pattern selector[ppu_addr[12:10]], ppu_addr[9:0]}, and `chr_hit` is 1 exactly when ppu_addr[13] is 0.
- R10: A write to any address other than the 14 listed ones changes no selector and leaves the mirroring unchanged. A cycle with `cpu_we` low also changes nothing. Matching uses all 16 address bits.
- R11: A register write takes effect on the clock edge where `cpu_we` is high, and the translated outputs reflect it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for both register decode and program translation |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, taken on every edge where it is high |
| ppu_addr | input | 14 | Video address for pattern translation |
| prg_addr | output | PRG_BANK_W+13 (21) | Translated program-ROM byte address |
| prg_hit | output | 1 | CPU address lies in the upper 32 KB |
| chr_addr | output | 18 | Translated pattern-ROM byte address |
| chr_hit | output | 1 | Video address lies in the low 8 KB |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The hardest case to reach from the ports is a write whose address sits next to a decoded one. Examples are 0x4503, 0x4508, 0x450F, 0x4518, 0x42FD, and any decoded address with bit 15 set. A missed address bit there would quietly load a selector.

The stimulus places writes on these neighbours directly. It then sweeps all twelve translation windows so that any stray load shows up in the output addresses. After the directed part, a long random phase biases addresses toward the register map and its neighbours, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam int BANK_W    = 8;
  localparam int PRG_SLOTS = 4;
  localparam int CHR_SLOTS = 8;
  localparam int PRG_OFF_W = 13;
  localparam int CHR_OFF_W = 10;

  localparam logic [15:0] ADR_MIR_SINGLE = 16'h42FE;
  localparam logic [15:0] ADR_MIR_AXIS   = 16'h42FF;
  localparam logic [15:0] ADR_PRG_FIRST  = 16'h4504;
  localparam logic [15:0] ADR_CHR_FIRST  = 16'h4510;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_map_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          addr,
  input  logic                 we,
  output logic                 mir_single_we,
  output logic                 mir_axis_we,
  output logic [PRG_SLOTS-1:0] prg_we,
  output logic [CHR_SLOTS-1:0] chr_we
);
  localparam int PRG_IDX_W = $clog2(PRG_SLOTS);
  localparam int CHR_IDX_W = $clog2(CHR_SLOTS);

  logic prg_block, chr_block;

  assign mir_single_we = we && (addr == ADR_MIR_SINGLE);
  assign mir_axis_we   = we && (addr == ADR_MIR_AXIS);
  assign prg_block     = (addr[15:PRG_IDX_W] == ADR_PRG_FIRST[15:PRG_IDX_W]);
  assign chr_block     = (addr[15:CHR_IDX_W] == ADR_CHR_FIRST[15:CHR_IDX_W]);

  for (genvar j = 0; j < PRG_SLOTS; j++) begin : g_prg_sel
    assign prg_we[j] = we && prg_block && (addr[PRG_IDX_W-1:0] == PRG_IDX_W'(j));
  end
  for (genvar k = 0; k < CHR_SLOTS; k++) begin : g_chr_sel
    assign chr_we[k] = we && chr_block && (addr[CHR_IDX_W-1:0] == CHR_IDX_W'(k));
  end

  // R10: one write reaches at most one register
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mir_single_we, mir_axis_we, prg_we, chr_we}));

  // R10: a low strobe enables nothing
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> ({mir_single_we, mir_axis_we, prg_we, chr_we} == '0));
endmodule

// File: rtl/cart_bank_file.sv
module cart_bank_file #(
  parameter int                     SLOTS = 4,
  parameter int                     W     = 8,
  parameter logic [SLOTS*W-1:0]     INIT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOTS-1:0]   we,
  input  logic [W-1:0]       wdata,
  output logic [SLOTS*W-1:0] banks
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)     banks[i*W +: W] <= INIT[i*W +: W];
      else if (we[i]) banks[i*W +: W] <= wdata;
    end

    // R6/R7: a selected slot takes the whole byte
    p_load_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we[i] |=> banks[i*W +: W] == $past(wdata));
  end

  // R10: no enable, no change
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(banks));
endmodule

// File: rtl/cart_addr_xlat.sv
module cart_addr_xlat #(
  parameter int SLOTS = 4,
  parameter int W     = 8,
  parameter int OFF_W = 13,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS*W-1:0] banks,
  input  logic [IDX_W-1:0]   slot,
  input  logic [OFF_W-1:0]   offset,
  output logic [W+OFF_W-1:0] rom_addr
);
  logic [W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot == IDX_W'(i)) picked = banks[i*W +: W];
    end
  end

  assign rom_addr = {picked, offset};
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_map_pkg::*;
#(
  parameter int PRG_BANKS  = 32,
  localparam int PRG_ADDR_W = BANK_W + PRG_OFF_W,
  localparam int CHR_ADDR_W = BANK_W + CHR_OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_we,
  input  logic [13:0]           ppu_addr,
  output logic [PRG_ADDR_W-1:0] prg_addr,
  output logic                  prg_hit,
  output logic [CHR_ADDR_W-1:0] chr_addr,
  output logic                  chr_hit,
  output logic [1:0]            mirror_mode
);
  localparam logic [PRG_SLOTS*BANK_W-1:0] PRG_INIT =
    {BANK_W'(PRG_BANKS-1), BANK_W'(PRG_BANKS-2), BANK_W'(1), BANK_W'(0)};

  function automatic logic [CHR_SLOTS*BANK_W-1:0] chr_identity();
    logic [CHR_SLOTS*BANK_W-1:0] r;
    for (int k = 0; k < CHR_SLOTS; k++) r[k*BANK_W +: BANK_W] = BANK_W'(k);
    return r;
  endfunction
  localparam logic [CHR_SLOTS*BANK_W-1:0] CHR_INIT = chr_identity();

  logic                        mir_single_we, mir_axis_we;
  logic [PRG_SLOTS-1:0]        prg_we;
  logic [CHR_SLOTS-1:0]        chr_we;
  logic [PRG_SLOTS*BANK_W-1:0] prg_banks;
  logic [CHR_SLOTS*BANK_W-1:0] chr_banks;
  mirror_e                     mirror_q;

  cart_wr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .we(cpu_we),
    .mir_single_we(mir_single_we), .mir_axis_we(mir_axis_we),
    .prg_we(prg_we), .chr_we(chr_we)
  );

  cart_bank_file #(.SLOTS(PRG_SLOTS), .W(BANK_W), .INIT(PRG_INIT)) u_prg_file (
    .clk(clk), .rst_n(rst_n), .we(prg_we), .wdata(cpu_wdata), .banks(prg_banks)
  );

  cart_bank_file #(.SLOTS(CHR_SLOTS), .W(BANK_W), .INIT(CHR_INIT)) u_chr_file (
    .clk(clk), .rst_n(rst_n), .we(chr_we), .wdata(cpu_wdata), .banks(chr_banks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             mirror_q <= MIR_VERT;
    else if (mir_single_we) mirror_q <= cpu_wdata[4] ? MIR_ONE_HI : MIR_ONE_LO;
    else if (mir_axis_we)   mirror_q <= cpu_wdata[4] ? MIR_HORZ : MIR_VERT;
  end
  assign mirror_mode = mirror_q;

  cart_addr_xlat #(.SLOTS(PRG_SLOTS), .W(BANK_W), .OFF_W(PRG_OFF_W)) u_prg_xlat (
    .banks(prg_banks), .slot(cpu_addr[14:13]), .offset(cpu_addr[12:0]), .rom_addr(prg_addr)
  );
  assign prg_hit = cpu_addr[15];

  cart_addr_xlat #(.SLOTS(CHR_SLOTS), .W(BANK_W), .OFF_W(CHR_OFF_W)) u_chr_xlat (
    .banks(chr_banks), .slot(ppu_addr[12:10]), .offset(ppu_addr[9:0]), .rom_addr(chr_addr)
  );
  assign chr_hit = ~ppu_addr[13];

  // R4: single-screen register picks low/high from bit 4
  p_mir_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h42FE) |=>
      mirror_mode == ($past(cpu_wdata[4]) ? 2'd3 : 2'd2));

  // R5: axis register picks horizontal/vertical from bit 4
  p_mir_axis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h42FF) |=>
      mirror_mode == ($past(cpu_wdata[4]) ? 2'd1 : 2'd0));

  // R10: mirroring holds without a write
  p_mir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> $stable(mirror_mode));

  // R8: in-window offset passes through untouched
  p_prg_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prg_hit |-> prg_addr[PRG_OFF_W-1:0] == cpu_addr[12:0]);

  // R9: pattern offset passes through untouched
  p_chr_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_hit |-> chr_addr[CHR_OFF_W-1:0] == ppu_addr[9:0]);
endmodule

// File: tb/cart_bank_regs_tb_top.sv
`timescale 1ns/1ps
module cart_bank_regs_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic [13:0] ppu_addr;
  logic [20:0] prg_addr;
  logic        prg_hit;
  logic [17:0] chr_addr;
  logic        chr_hit;
  logic [1:0]  mirror_mode;

  always #2.5 clk = ~clk;

  cart_bank_regs #(.PRG_BANKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .prg_hit(prg_hit),
    .chr_addr(chr_addr), .chr_hit(chr_hit), .mirror_mode(mirror_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int prg_m[4];
  int chr_m[8];
  int mir_m;

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    prg_m[0] = 0; prg_m[1] = 1; prg_m[2] = (N - 2) & 255; prg_m[3] = (N - 1) & 255;
    for (int k = 0; k < 8; k++) chr_m[k] = k;
    mir_m = 0;
  endtask

  // one cycle: drive, compare outputs against model, then advance model past the edge
  task automatic cycle(input logic [15:0] ca, input logic [7:0] d, input logic we,
                       input logic [13:0] pa, input string tag);
    @(negedge clk);
    cpu_addr = ca; cpu_wdata = d; cpu_we = we; ppu_addr = pa;
    #1;
    check("R8 hit", prg_hit, ca[15]);
    if (ca[15]) check(tag, prg_addr, (longint'(prg_m[ca[14:13]]) << 13) | ca[12:0]);
    check("R9 hit", chr_hit, !pa[13]);
    if (!pa[13]) check(tag, chr_addr, (longint'(chr_m[pa[12:10]]) << 10) | pa[9:0]);
    check(tag, mirror_mode, mir_m);
    if (we) begin
      if (ca == 16'h42FE) mir_m = d[4] ? 3 : 2;
      else if (ca == 16'h42FF) mir_m = d[4] ? 1 : 0;
      else if (ca >= 16'h4504 && ca <= 16'h4507) prg_m[ca - 16'h4504] = d;
      else if (ca >= 16'h4510 && ca <= 16'h4517) chr_m[ca - 16'h4510] = d;
    end
  endtask

  // visit every translation window without writing
  task automatic sweep(input string tag);
    for (int w = 0; w < 8; w++)
      cycle(16'h8000 | 16'(w % 4) << 13 | 16'(w * 37), 8'h00, 1'b0,
            14'(w) << 10 | 14'(w * 91), tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; ppu_addr = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1, R2, R3: reset map and mirroring
    for (int j = 0; j < 4; j++) cycle(16'h8000 | 16'(j) << 13 | 16'h0123, 8'h0, 1'b0, 14'h0, "R1");
    for (int k = 0; k < 8; k++) cycle(16'h0000, 8'h0, 1'b0, 14'(k) << 10 | 14'h2A5, "R2");
    cycle(16'h1234, 8'h0, 1'b0, 14'h3FFF, "R3");

    // R4: single-screen select both ways
    cycle(16'h42FE, 8'h10, 1'b1, 14'h0, "R4");
    cycle(16'h0000, 8'h00, 1'b0, 14'h0, "R4");
    cycle(16'h42FE, 8'hEF, 1'b1, 14'h0, "R4");
    cycle(16'h0000, 8'h00, 1'b0, 14'h0, "R4");
    // R5: horizontal then vertical
    cycle(16'h42FF, 8'h1F, 1'b1, 14'h0, "R5");
    cycle(16'h0000, 8'h00, 1'b0, 14'h0, "R5");
    cycle(16'h42FF, 8'hE0, 1'b1, 14'h0, "R5");
    cycle(16'h0000, 8'h00, 1'b0, 14'h0, "R5");

    // R6, R11: program selectors, checked the very next cycle
    for (int j = 0; j < 4; j++) begin
      cycle(16'h4504 + 16'(j), 8'hA0 + 8'(j * 17), 1'b1, 14'h0, "R6");
      cycle(16'h8000 | 16'(j) << 13 | 16'h1FFF, 8'h0, 1'b0, 14'h0, "R11");
    end
    // R7, R11: pattern selectors
    for (int k = 0; k < 8; k++) begin
      cycle(16'h4510 + 16'(k), 8'hFF - 8'(k * 13), 1'b1, 14'h0, "R7");
      cycle(16'h0000, 8'h0, 1'b0, 14'(k) << 10 | 14'h3FF, "R11");
    end
    sweep("R8");

    // R10: decode neighbours, aliases and a low strobe
    cycle(16'h42FD, 8'h10, 1'b1, 14'h0, "R10");
    cycle(16'h4503, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'h4508, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'h450F, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'h4518, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'hC504, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'h0510, 8'h55, 1'b1, 14'h0, "R10");
    cycle(16'hC2FF, 8'h10, 1'b1, 14'h0, "R10");
    cycle(16'h4505, 8'h33, 1'b0, 14'h0, "R10");
    cycle(16'h4512, 8'h33, 1'b0, 14'h0, "R10");
    cycle(16'h42FE, 8'h10, 1'b0, 14'h0, "R10");
    sweep("R10");

    // R9: out-of-window video addresses
    cycle(16'h0000, 8'h0, 1'b0, 14'h2000, "R9");
    cycle(16'h0000, 8'h0, 1'b0, 14'h3C00, "R9");

    // mixed random traffic biased toward the register map
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      case ($urandom % 8)
        0: a = 16'h4504 + 16'($urandom % 4);
        1: a = 16'h4510 + 16'($urandom % 8);
        2: a = 16'h42FE + 16'($urandom % 2);
        3: a = 16'h4500 + 16'($urandom % 32);
        4: a = 16'h42FC + 16'($urandom % 6);
        5: a = (16'h4504 + 16'($urandom % 20)) ^ (16'h1 << ($urandom % 16));
        default: a = 16'($urandom);
      endcase
      cycle(a, 8'($urandom), 1'($urandom), 14'($urandom), "R10");
    end

    // reset again mid-run restores the map (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    sweep("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule